// File: doc/BRIEF.md
# Banked Preload Line-Count Registers with Access Checking

This block holds one 32-bit configuration register per preload channel. Each register gives the number of cache lines that its channel moves. Software does not address the channels directly. It first writes a channel-select register. It then issues coprocessor-style reads and writes, and these reach the channel that the select register names. The transfer engine reads all the stored line counts on a flat output bus.

Every access carries two attributes: its security state (Secure or Nonsecure) and its privilege (User or privileged). The block checks them against two inputs:

- a global Nonsecure-enable bit;
- a per-channel user-access bit.

A permitted access completes. A refused access changes nothing, returns zero and raises a one-cycle undefined-access pulse. The cache size is set at build time. It decides which bits of the register are writable: bits [N:6], with N equal to 14, 15, 16 or 17 for caches of 128, 256, 512 or 1024 KB. With no cache, every bit reads as zero.

Top module: `pl_linecnt_bank`

## Requirements
- R1: A synchronous active-low reset clears every channel register to zero and sets the select register to channel 0. After reset, `rsp_valid`, `rsp_data`, `undef_pulse` and `ch_lines` are all zero.
- R2: An access reaches the channel held in the select register. When a select write and an access happen in the same cycle, the access uses the select value held before that write.
- R3: Only bits [N:6] are stored, with N = 14/15/16/17 for a 128/256/512/1024 KB cache. Other bits read as zero and writes to them are ignored. For the default 256 KB the mask is 0x0000FFC0.
- R4: With a 0 KB cache, every channel reads as zero and writes have no effect on any stored value.
- R5: A Secure privileged access always completes.
- R6: A Nonsecure privileged access completes only when `ns_enable` is 1.
- R7: A Secure User access completes only when the selected channel's bit in `user_en` is 1.
- R8: A Nonsecure User access completes only when `ns_enable` is 1 and the selected channel's `user_en` bit is 1.
- R9: A refused access leaves every register unchanged and does not raise `rsp_valid`. In the following cycle it drives `rsp_data` to zero and raises `undef_pulse` for exactly one cycle.
- R10: When the select register holds a value of `NUM_CH` or more, any access is refused, whatever its security state and privilege.
- R11: A completed read raises `rsp_valid` with the stored value in the following cycle. A completed write raises no `rsp_valid`, and the new value appears on `ch_lines` in the following cycle. `rsp_data` is zero whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the channel-select register |
| sel_wdata | input | SEL_W | New channel-select value |
| ns_enable | input | 1 | Nonsecure-enable bit |
| user_en | input | NUM_CH | Per-channel user-access bits |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ns | input | 1 | 1 = Nonsecure, 0 = Secure |
| acc_user | input | 1 | 1 = User, 0 = privileged |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a completed read |
| rsp_data | output | 32 | Read data, zero when not valid |
| undef_pulse | output | 1 | One-cycle pulse for a refused access |
| ch_lines | output | NUM_CH*32 | Stored value of each channel, channel 0 in the low word |

## Verification
The properties assume that `acc_write`, `acc_ns`, `acc_user`, `user_en` and `ns_enable` are stable and known around each rising edge at which `acc_valid` is high. They also assume that at most one access arrives per cycle. The stimulus meets this by changing every input only on the falling clock edge and by presenting one access per cycle.

The stimulus covers all four combinations of security state and privilege, each with its enable bits both set and cleared. It also includes out-of-range select values, and a select write in the same cycle as an access. A second copy of the block, built with no cache, receives the same inputs so that the zero-width case is observed at its ports.

// File: rtl/pl_linecnt_pkg.sv
// Package: shared constants and cache-size helpers for the line-count bank.
// Assumes cache sizes are given in KB; unknown sizes behave as no cache.
package pl_linecnt_pkg;

    localparam int REG_W    = 32;
    localparam int FIELD_LO = 6;

    // Top bit of the line-count field for a given cache size.
    function automatic int field_hi(input int cache_kb);
        case (cache_kb)
            128:     return 14;
            256:     return 15;
            512:     return 16;
            1024:    return 17;
            default: return FIELD_LO;
        endcase
    endfunction

    // True when the configuration stores any line-count bits at all.
    function automatic bit has_field(input int cache_kb);
        return field_hi(cache_kb) > FIELD_LO;
    endfunction

    // Mask of the writable bits for a given cache size.
    function automatic logic [REG_W-1:0] field_mask(input int cache_kb);
        logic [REG_W-1:0] m;
        m = '0;
        if (has_field(cache_kb)) begin
            for (int b = FIELD_LO; b <= field_hi(cache_kb); b++) begin
                m[b] = 1'b1;
            end
        end
        return m;
    endfunction

    // Registered response to one access.
    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
        logic             undef;
    } rsp_t;

endpackage

// File: rtl/pl_chan_select.sv
// Module: channel-select register with one-hot decode.
// Assumes NUM_CH <= 2**SEL_W. Values of NUM_CH or more decode to no channel.
module pl_chan_select #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_wdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic [NUM_CH-1:0] sel_oh,
    output logic              in_range
);

    // Hold the selected channel number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= sel_wdata;
        end
    end

    // Decode the held number into a one-hot channel vector.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            sel_oh[i] = (sel_q == SEL_W'(i));
        end
    end

    // Any decoded channel means the select value is in range.
    assign in_range = |sel_oh;

endmodule

// File: rtl/pl_access_check.sv
// Module: permission decision for one register access.
// Assumes user_bit already belongs to the selected channel. Purely combinational.
module pl_access_check (
    input  logic acc_ns,
    input  logic acc_user,
    input  logic ns_enable,
    input  logic user_bit,
    input  logic in_range,
    output logic allow
);

    logic ns_ok;
    logic user_ok;

    // A Nonsecure access needs the Nonsecure-enable bit.
    assign ns_ok   = !acc_ns || ns_enable;

    // A User access needs the channel's user-access bit.
    assign user_ok = !acc_user || user_bit;

    // Both conditions hold and the select value names a real channel.
    assign allow   = in_range && ns_ok && user_ok;

endmodule

// File: rtl/pl_chan_reg.sv
// Module: one channel's line-count register.
// Stores only bits [N:6], where N comes from CACHE_KB. With no cache it stores nothing and reads zero.
module pl_chan_reg
    import pl_linecnt_pkg::*;
#(
    parameter int CACHE_KB = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value
);

    localparam int HI = field_hi(CACHE_KB);

    generate
        if (has_field(CACHE_KB)) begin : g_field
            logic [HI:FIELD_LO] q;
            logic               unused_wbits;

            // Capture the writable field on a permitted write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en) begin
                    q <= wdata[HI:FIELD_LO];
                end
            end

            // The bits outside the field are dropped.
            assign unused_wbits = ^{wdata[REG_W-1:HI+1], wdata[FIELD_LO-1:0]};

            // Place the field at its bit position; every other bit is zero.
            assign value = {{(REG_W-1-HI){1'b0}}, q, {FIELD_LO{1'b0}}};
        end else begin : g_empty
            logic unused_ins;

            // Nothing is stored when there is no cache.
            assign unused_ins = ^{clk, rst_n, wr_en, wdata};
            assign value      = '0;
        end
    endgenerate

endmodule

// File: rtl/pl_linecnt_bank.sv
// Module: bank of per-channel line-count registers with access checking.
// Accesses go through a select register. The result of each access is registered and shows one cycle later.
// Assumes at most one access per cycle, with its attributes stable at the clock edge.
module pl_linecnt_bank
    import pl_linecnt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SEL_W    = 3,
    parameter int CACHE_KB = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_wr,
    input  logic [SEL_W-1:0]        sel_wdata,
    input  logic                    ns_enable,
    input  logic [NUM_CH-1:0]       user_en,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic                    acc_ns,
    input  logic                    acc_user,
    input  logic [REG_W-1:0]        acc_wdata,
    output logic                    rsp_valid,
    output logic [REG_W-1:0]        rsp_data,
    output logic                    undef_pulse,
    output logic [NUM_CH*REG_W-1:0] ch_lines
);

    logic [SEL_W-1:0]  sel_q;
    logic [NUM_CH-1:0] sel_oh;
    logic              sel_in_range;
    logic              sel_user_bit;
    logic              allow;
    logic [REG_W-1:0]  ch_val [NUM_CH];
    logic [REG_W-1:0]  rd_mux;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    pl_chan_select #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .sel_q     (sel_q),
        .sel_oh    (sel_oh),
        .in_range  (sel_in_range)
    );

    // The user-access bit of the selected channel.
    assign sel_user_bit = |(user_en & sel_oh);

    pl_access_check u_chk_acc (
        .acc_ns    (acc_ns),
        .acc_user  (acc_user),
        .ns_enable (ns_enable),
        .user_bit  (sel_user_bit),
        .in_range  (sel_in_range),
        .allow     (allow)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pl_chan_reg #(
                .CACHE_KB (CACHE_KB)
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (acc_valid && acc_write && allow && sel_oh[c]),
                .wdata (acc_wdata),
                .value (ch_val[c])
            );
            assign ch_lines[c*REG_W +: REG_W] = ch_val[c];
        end
    endgenerate

    // Choose the selected channel's value for a read.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_oh[i]) begin
                rd_mux = rd_mux | ch_val[i];
            end
        end
    end

    // Form the next response from the current access.
    always_comb begin
        rsp_d.valid = acc_valid && !acc_write && allow;
        rsp_d.data  = (acc_valid && !acc_write && allow) ? rd_mux : '0;
        rsp_d.undef = acc_valid && !allow;
    end

    // Register the response so that it shows in the cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_data    = rsp_q.data;
    assign undef_pulse = rsp_q.undef;

endmodule

// File: rtl/pl_linecnt_bank_chk.sv
// Checker: temporal properties of the line-count bank, bound to every instance.
// Assumes one access per cycle, with its attributes stable at the clock edge.
module pl_linecnt_bank_chk
    import pl_linecnt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SEL_W    = 3,
    parameter int CACHE_KB = 256
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ns_enable,
    input logic [NUM_CH-1:0]       user_en,
    input logic                    acc_valid,
    input logic                    acc_write,
    input logic                    acc_ns,
    input logic                    acc_user,
    input logic                    rsp_valid,
    input logic [REG_W-1:0]        rsp_data,
    input logic                    undef_pulse,
    input logic [NUM_CH*REG_W-1:0] ch_lines,
    input logic [SEL_W-1:0]        sel_q
);

    localparam logic [REG_W-1:0] MASK = field_mask(CACHE_KB);

    logic chk_in_range;
    logic chk_ub;

    // Independent range check and user-bit lookup for the held select value.
    always_comb begin
        chk_in_range = 1'b0;
        chk_ub       = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(sel_q) == i) begin
                chk_in_range = 1'b1;
                chk_ub       = user_en[i];
            end
        end
    end

    p_field_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_data & ~MASK) == '0);

    p_stored_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_lines[REG_W-1:0] & ~MASK) == '0);

    p_secure_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ns && !acc_user && chk_in_range) |=> !undef_pulse);

    p_ns_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ns && !ns_enable) |=> undef_pulse);

    p_user_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_user && !chk_ub) |=> undef_pulse);

    p_ns_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ns && acc_user && ns_enable && chk_ub) |=> !undef_pulse);

    p_refused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_pulse |-> (!rsp_valid && rsp_data == '0));

    p_refused_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_pulse |-> $stable(ch_lines));

    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !chk_in_range) |=> undef_pulse);

    p_read_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_valid && !acc_write));

    p_idle_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_data == '0);

endmodule

bind pl_linecnt_bank pl_linecnt_bank_chk #(
    .NUM_CH   (NUM_CH),
    .SEL_W    (SEL_W),
    .CACHE_KB (CACHE_KB)
) u_bank_chk (.*);

// File: tb/pl_linecnt_bank_bench.sv
`timescale 1ns/1ps
module pl_linecnt_bank_bench;

    localparam int          NUM_CH = 4;
    localparam logic [31:0] MASK   = 32'h0000_FFC0; // R3: bits [15:6] for 256 KB

    typedef struct {
        bit          valid;
        logic [31:0] data;
        bit          undef;
        string       tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sel_wr = 1'b0;
    logic [2:0]         sel_wdata = '0;
    logic               ns_enable = 1'b0;
    logic [NUM_CH-1:0]  user_en = '0;
    logic               acc_valid = 1'b0;
    logic               acc_write = 1'b0;
    logic               acc_ns = 1'b0;
    logic               acc_user = 1'b0;
    logic [31:0]        acc_wdata = '0;
    logic               rsp_valid, z_rsp_valid;
    logic [31:0]        rsp_data, z_rsp_data;
    logic               undef_pulse, z_undef;
    logic [NUM_CH*32-1:0] ch_lines, z_lines;

    int          n_tests = 0;
    int          n_fail  = 0;
    exp_t        sb_q[$];
    logic [31:0] mem_m [NUM_CH];
    int          sel_m = 0;

    always #4 clk = ~clk;

    pl_linecnt_bank u_pl_linecnt_bank (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .ns_enable(ns_enable), .user_en(user_en), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_ns(acc_ns), .acc_user(acc_user),
        .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .undef_pulse(undef_pulse), .ch_lines(ch_lines)
    );

    pl_linecnt_bank #(.CACHE_KB(0)) u_zero (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .ns_enable(ns_enable), .user_en(user_en), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_ns(acc_ns), .acc_user(acc_user),
        .acc_wdata(acc_wdata), .rsp_valid(z_rsp_valid), .rsp_data(z_rsp_data),
        .undef_pulse(z_undef), .ch_lines(z_lines)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each registered response with the queued expectation.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(rsp_valid == e.valid, {e.tag, " valid"}, 32'(rsp_valid), 32'(e.valid));
            check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
            check(undef_pulse == e.undef, {e.tag, " undef"}, 32'(undef_pulse), 32'(e.undef));
            check(z_rsp_data == '0 && z_undef == e.undef, {e.tag, " R4 zero-cache copy"},
                  z_rsp_data, 32'h0);
        end
    end

    // Driver: one access per cycle, pushing its expected response.
    task automatic access(input bit wr, input bit ns, input bit usr, input logic [31:0] d,
                          input string tag, input bit with_sel = 0, input int nsel = 0);
        exp_t e;
        bit   allow;
        allow = (sel_m < NUM_CH) && (!usr || user_en[sel_m % NUM_CH]) && (!ns || ns_enable);
        acc_valid = 1'b1; acc_write = wr; acc_ns = ns; acc_user = usr; acc_wdata = d;
        if (with_sel) begin
            sel_wr = 1'b1; sel_wdata = 3'(nsel);
        end
        e.valid = allow && !wr;
        e.data  = (allow && !wr) ? mem_m[sel_m] : 32'h0;
        e.undef = !allow;
        e.tag   = tag;
        if (allow && wr) mem_m[sel_m] = d & MASK;
        sb_q.push_back(e);
        @(negedge clk);
        acc_valid = 1'b0; sel_wr = 1'b0;
        if (with_sel) sel_m = nsel;
    endtask

    task automatic idle(input string tag);
        exp_t e;
        e.valid = 0; e.data = '0; e.undef = 0; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic set_sel(input int v);
        sel_wr = 1'b1; sel_wdata = 3'(v);
        idle("R2 select write");
        sel_wr = 1'b0; sel_m = v;
    endtask

    task automatic check_lines(input int ch, input string tag);
        check(ch_lines[ch*32 +: 32] == mem_m[ch], tag, ch_lines[ch*32 +: 32], mem_m[ch]);
        check(z_lines == '0, "R4 zero-cache lines", z_lines[31:0], 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) mem_m[i] = '0;
        repeat (4) @(negedge clk);
        // R1: state after reset
        check(rsp_valid == 0 && undef_pulse == 0 && rsp_data == 0, "R1 outputs after reset",
              rsp_data, 32'h0);
        check(ch_lines == '0, "R1 registers after reset", ch_lines[31:0], 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) begin
            set_sel(c);
            access(0, 0, 0, '0, "R1 read after reset");
        end

        // R3/R5: Secure privileged writes are masked to the field
        set_sel(0);
        access(1, 0, 0, 32'hFFFF_FFFF, "R5 secure priv write");
        check_lines(0, "R11 write visible on ch_lines");
        access(0, 0, 0, '0, "R3 masked read ch0");
        set_sel(1);
        access(1, 0, 0, 32'h1234_5678, "R5 secure priv write ch1");
        access(0, 0, 0, '0, "R3 read ch1 back-to-back");
        idle("R9 no pulse when idle");
        set_sel(2);
        access(1, 0, 0, 32'h0000_A5C0, "R2 write ch2");
        access(0, 0, 0, '0, "R2 read ch2");

        // R6: Nonsecure privileged
        ns_enable = 1'b0;
        access(1, 1, 0, 32'h0000_3300, "R6 NS priv write refused");
        idle("R9 undef lasts one cycle");
        access(0, 1, 0, '0, "R6 NS priv read refused");
        access(0, 0, 0, '0, "R9 value unchanged after refusal");
        ns_enable = 1'b1;
        access(1, 1, 0, 32'h0000_3300, "R6 NS priv write allowed");
        access(0, 1, 0, '0, "R6 NS priv read allowed");

        // R7: Secure User
        ns_enable = 1'b0;
        user_en = 4'b1011;
        access(1, 0, 1, 32'h0000_0FC0, "R7 secure user refused (other bits set)");
        check_lines(2, "R9 ch2 unchanged after refusal");
        user_en = 4'b0100;
        access(1, 0, 1, 32'h0000_0FC0, "R7 secure user allowed");
        access(0, 0, 1, '0, "R7 secure user read");

        // R8: Nonsecure User
        access(0, 1, 1, '0, "R8 NS user, ns_enable low");
        ns_enable = 1'b1; user_en = 4'b0000;
        access(0, 1, 1, '0, "R8 NS user, user bit low");
        user_en = 4'b0100;
        access(1, 1, 1, 32'h0000_8040, "R8 NS user write allowed");
        access(0, 1, 1, '0, "R8 NS user read allowed");

        // R10: out-of-range select
        user_en = 4'b1111;
        set_sel(5);
        access(0, 0, 0, '0, "R10 secure priv read out of range");
        access(1, 1, 1, 32'hFFFF_FFFF, "R10 NS user write out of range");
        set_sel(7);
        access(1, 0, 0, 32'hFFFF_FFFF, "R10 secure priv write out of range");
        set_sel(3);
        access(0, 0, 0, '0, "R10 ch3 untouched");

        // R2: select written in the same cycle as an access
        access(1, 0, 0, 32'h0000_7780, "R2 access uses old select", 1, 1);
        access(0, 0, 0, '0, "R2 read uses new select ch1");
        set_sel(3);
        access(0, 0, 0, '0, "R2 ch3 got same-cycle write");
        check_lines(3, "R11 ch3 on ch_lines");

        repeat (2) idle("R11 idle output zero");
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule